// File: doc/BRIEF.md
# Audio Error Concealment and Output Level Control

This block takes a byte-serial stream of 16-bit stereo samples. Each sample arrives as three bytes: an error pointer byte, then the low data byte, then the high data byte. The block rebuilds each sample and repairs the flagged ones separately for each channel. It holds one sample of lookahead per channel, so it knows whether the following sample of that channel is good before it emits the current one. A lone flagged sample becomes the average of its two neighbours. In a longer run of flagged samples, the value is held at the last emitted value, and the last sample of the run is averaged with the next good sample.

After concealment, the sample goes through a level stage driven by a mute pin and two control bits. That stage applies full mute, a fixed −12 dB step (an arithmetic right shift by two), or zero-cross mute. Zero-cross mute lets samples pass until a near-zero negative sample appears, then silences the channel. Each result leaves as one registered sample tagged with its channel: left when the tag is high, right when it is low.

Top module: `audio_conceal_mute`

## Requirements
- R1: An input triple is pointer byte, low byte, high byte, each accepted on a cycle with `in_valid` high. `in_left` is sampled with the pointer byte. A nonzero pointer byte flags the sample as bad. A completed sample produces an output (with `out_valid` high for one cycle, the cycle after its high byte is accepted) only if that channel already holds a pending sample. The output is that pending sample.
- R2: An unflagged sample is emitted unchanged, in arrival order within its channel.
- R3: A flagged sample whose next same-channel sample is good becomes floor((P+N)/2), using signed values. P is the previous value emitted on that channel and N is the next sample.
- R4: A flagged sample whose next same-channel sample is also flagged is emitted as the previous value emitted on that channel. The last sample of such a run follows R3.
- R5: The two channels keep separate state. `out_left` is 1 for a left sample and 0 for a right sample.
- R6: With `mute_pin`=1, `attm_en`=0 and `zc_en`=0, the emitted sample is 0.
- R7: With `attm_en`=1 and zero-cross mode inactive, the emitted sample is the concealed value shifted arithmetically right by 2, whatever the value of `mute_pin`.
- R8: Zero-cross mode is active when `zc_en`=1 and `mute_pin`=1. While it is active, a channel passes samples (attenuated per R7 if `attm_en`=1) until a concealed sample has bits [15:10] all ones. That sample and every later sample of that channel are 0 until the mode goes inactive.
- R9: After reset, `out_valid`=0, `out_sample`=0, no sample is pending, and the previous-value reference of each channel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Pointer, low or high byte |
| in_left | input | 1 | Channel of the triple, sampled with the pointer byte (1 = left) |
| mute_pin | input | 1 | Mute request |
| zc_en | input | 1 | Zero-cross mute enable |
| attm_en | input | 1 | −12 dB attenuation enable |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | 1 | Channel tag of the output sample (1 = left) |
| out_sample | output | 16 | Concealed, level-controlled sample |

## Verification
The assertions check on every cycle the facts that follow from the control inputs alone. Each output must be caused by a completed input triple, and the byte phase must stay in range. Full mute must give zero. Attenuated output must keep the headroom that a shift by two leaves. A channel latched in zero-cross mode must stay at zero, and a clean sample must pass through unmuted. Only the bench's scenarios can show the concealment values themselves: the averaging with floor rounding on negative sums, the hold through a run and the averaging at its end, the separation of the two channels, and the order in which zero-cross mute engages and releases.

// File: rtl/aim_pkg.sv
package aim_pkg;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned SMP_W     = 2 * BYTE_W;
  parameter int unsigned ZC_BITS   = 6;
  parameter int unsigned ATT_SHIFT = 2;
  parameter int unsigned NCH       = 2;
  parameter int unsigned PHASES    = 3;
  parameter int unsigned PH_W      = $clog2(PHASES);

  typedef logic [SMP_W-1:0] sample_t;

  // floor of the signed mean of two samples
  function automatic sample_t mid_value(input sample_t a, input sample_t b);
    logic signed [SMP_W:0] s;
    s = $signed({a[SMP_W-1], a}) + $signed({b[SMP_W-1], b});
    return s[SMP_W:1];
  endfunction

  // fixed attenuation step
  function automatic sample_t atten_step(input sample_t x);
    return sample_t'($signed(x) >>> ATT_SHIFT);
  endfunction

  // near-zero negative value detector for zero-cross mute
  function automatic logic zc_hit(input sample_t x);
    return &x[SMP_W-1 -: ZC_BITS];
  endfunction
endpackage

// File: rtl/aim_byte_collect.sv
module aim_byte_collect
  import aim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_left,
  output logic              smp_done,
  output sample_t           smp_val,
  output logic              smp_flag,
  output logic              smp_left,
  output logic [PH_W-1:0]   phase
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

  logic [BYTE_W-1:0] low_q;
  logic              flag_q;
  logic              left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= '0;
      low_q  <= '0;
      flag_q <= 1'b0;
      left_q <= 1'b0;
    end else if (in_valid) begin
      case (phase)
        PH_W'(0): begin
          flag_q <= |in_byte;
          left_q <= in_left;
          phase  <= PH_W'(1);
        end
        PH_W'(1): begin
          low_q <= in_byte;
          phase <= PH_LAST;
        end
        default: phase <= '0;
      endcase
    end
  end

  assign smp_done = in_valid && (phase == PH_LAST);
  assign smp_val  = {in_byte, low_q};
  assign smp_flag = flag_q;
  assign smp_left = left_q;
endmodule

// File: rtl/aim_conceal_lane.sv
module aim_conceal_lane
  import aim_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take,
  input  sample_t new_val,
  input  logic    new_flag,
  output logic    emit,
  output sample_t emit_val,
  output sample_t pend_val,
  output logic    pend_flag
);
  logic    pend_v;
  sample_t last_out;

  always_comb begin
    if (!pend_flag)     emit_val = pend_val;
    else if (new_flag)  emit_val = last_out;
    else                emit_val = mid_value(last_out, new_val);
  end

  assign emit = take && pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_val  <= '0;
      pend_flag <= 1'b0;
      last_out  <= '0;
    end else if (take) begin
      pend_v    <= 1'b1;
      pend_val  <= new_val;
      pend_flag <= new_flag;
      if (pend_v) last_out <= emit_val;
    end
  end
endmodule

// File: rtl/aim_level_ctrl.sv
module aim_level_ctrl
  import aim_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           emit,
  input  logic           emit_left,
  input  sample_t        emit_val,
  input  logic           mute_pin,
  input  logic           zc_en,
  input  logic           attm_en,
  output logic           out_valid,
  output logic           out_left,
  output sample_t        out_sample,
  output logic [NCH-1:0] zc_latched,
  output logic           zc_cur
);
  logic    zc_mode;
  logic    hit;
  sample_t lvl;

  assign zc_mode = zc_en && mute_pin;
  assign hit     = zc_hit(emit_val);
  assign zc_cur  = zc_latched[emit_left];

  always_comb begin
    if (zc_mode && (zc_cur || hit))   lvl = '0;
    else if (mute_pin && !attm_en && !zc_mode) lvl = '0;
    else if (attm_en)                 lvl = atten_step(emit_val);
    else                              lvl = emit_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zc_latched <= '0;
    end else if (!zc_mode) begin
      zc_latched <= '0;
    end else if (emit && hit) begin
      zc_latched[emit_left] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_left   <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_left   <= emit_left;
        out_sample <= lvl;
      end
    end
  end
endmodule

// File: rtl/audio_conceal_mute.sv
module audio_conceal_mute
  import aim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_left,
  input  logic              mute_pin,
  input  logic              zc_en,
  input  logic              attm_en,
  output logic              out_valid,
  output logic              out_left,
  output logic [SMP_W-1:0]  out_sample
);
  logic            smp_done;
  sample_t         smp_val;
  logic            smp_flag;
  logic            smp_left;
  logic [PH_W-1:0] phase;

  logic [NCH-1:0]  lane_emit;
  sample_t         lane_val  [NCH];
  sample_t         lane_pend [NCH];
  logic [NCH-1:0]  lane_pflag;

  // named wires for the checker
  logic            emit_any;
  sample_t         emit_val;
  sample_t         emit_pend;
  logic            emit_flag;
  logic [NCH-1:0]  zc_latched;
  logic            zc_cur;

  aim_byte_collect u_collect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_left(in_left), .smp_done(smp_done), .smp_val(smp_val),
    .smp_flag(smp_flag), .smp_left(smp_left), .phase(phase)
  );

  // lane 0 = right, lane 1 = left
  for (genvar c = 0; c < NCH; c++) begin : g_lane
    aim_conceal_lane u_lane (
      .clk(clk), .rst_n(rst_n),
      .take(smp_done && (smp_left == c[0])),
      .new_val(smp_val), .new_flag(smp_flag),
      .emit(lane_emit[c]), .emit_val(lane_val[c]),
      .pend_val(lane_pend[c]), .pend_flag(lane_pflag[c])
    );
  end

  assign emit_any  = lane_emit[smp_left];
  assign emit_val  = lane_val[smp_left];
  assign emit_pend = lane_pend[smp_left];
  assign emit_flag = lane_pflag[smp_left];

  aim_level_ctrl u_level (
    .clk(clk), .rst_n(rst_n), .emit(emit_any), .emit_left(smp_left),
    .emit_val(emit_val), .mute_pin(mute_pin), .zc_en(zc_en),
    .attm_en(attm_en), .out_valid(out_valid), .out_left(out_left),
    .out_sample(out_sample), .zc_latched(zc_latched), .zc_cur(zc_cur)
  );
endmodule

// File: rtl/aim_checker.sv
module aim_checker
  import aim_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            smp_done,
  input logic [PH_W-1:0] phase,
  input logic            mute_pin,
  input logic            zc_en,
  input logic            attm_en,
  input logic            emit_flag,
  input sample_t         emit_pend,
  input logic            zc_cur,
  input logic            out_valid,
  input sample_t         out_sample
);
  assert_out_follows_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_done));

  assert_phase_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PH_W'(PHASES));

  assert_clean_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(!mute_pin && !attm_en && !emit_flag) |-> out_sample == $past(emit_pend));

  assert_full_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(mute_pin && !attm_en && !zc_en) |-> out_sample == '0);

  assert_atten_headroom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(attm_en && !(zc_en && mute_pin))
    |-> ((&out_sample[SMP_W-1 -: ATT_SHIFT+1]) || !(|out_sample[SMP_W-1 -: ATT_SHIFT+1])));

  assert_zc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(zc_en && mute_pin && zc_cur) |-> out_sample == '0);
endmodule

bind audio_conceal_mute aim_checker u_chk (
  .clk(clk), .rst_n(rst_n), .smp_done(smp_done), .phase(phase),
  .mute_pin(mute_pin), .zc_en(zc_en), .attm_en(attm_en),
  .emit_flag(emit_flag), .emit_pend(emit_pend), .zc_cur(zc_cur),
  .out_valid(out_valid), .out_sample(out_sample)
);

// File: tb/tb_audio_conceal_mute.sv
module tb_audio_conceal_mute;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_left;
  logic        mute_pin, zc_en, attm_en;
  logic        out_valid, out_left;
  logic [15:0] out_sample;

  int n_cmp = 0;
  int n_bad = 0;
  logic        got_v, got_l;
  logic [15:0] got_s;

  always #5 clk = ~clk;

  audio_conceal_mute dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_left(in_left), .mute_pin(mute_pin), .zc_en(zc_en), .attm_en(attm_en),
    .out_valid(out_valid), .out_left(out_left), .out_sample(out_sample)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_left = 1'b0;
    mute_pin = 1'b0; zc_en = 1'b0; attm_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic left, input logic [7:0] ptr, input logic [15:0] val);
    @(negedge clk); in_valid = 1'b1; in_byte = ptr; in_left = left;
    @(negedge clk); in_byte = val[7:0]; in_left = ~left;
    @(negedge clk); in_byte = val[15:8];
    @(negedge clk); in_valid = 1'b0;
    got_v = out_valid; got_l = out_left; got_s = out_sample;
  endtask

  task automatic expect_none(input string req);
    check(req, 32'(got_v), 32'd0);
  endtask

  task automatic expect_out(input string req, input logic left, input logic [15:0] s);
    check(req, 32'(got_v), 32'd1);
    check(req, 32'(got_l), 32'(left));
    check(req, 32'(got_s), 32'(s));
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R9 valid", 32'(out_valid), 32'd0);
    check("R9 sample", 32'(out_sample), 32'd0);
    send(1'b1, 8'h00, 16'd100);
    expect_none("R9 first sample no output");
    send(1'b1, 8'h00, 16'd200);
    expect_out("R1 R2 pass", 1'b1, 16'd100);
    send(1'b1, 8'h00, 16'd300);
    expect_out("R2 order", 1'b1, 16'd200);
  endtask

  task automatic t_isolated();
    do_reset();
    send(1'b1, 8'h00, 16'd1000);
    send(1'b1, 8'h01, 16'd7777);
    expect_out("R2", 1'b1, 16'd1000);
    send(1'b1, 8'h00, 16'd3000);
    expect_out("R3 average", 1'b1, 16'd2000);
    send(1'b1, 8'h00, 16'hFFFD);
    expect_out("R2", 1'b1, 16'd3000);
    send(1'b1, 8'h20, 16'd5555);
    expect_out("R2 negative", 1'b1, 16'hFFFD);
    send(1'b1, 8'h00, 16'd0);
    expect_out("R3 floor negative", 1'b1, 16'hFFFE);
  endtask

  task automatic t_run();
    do_reset();
    send(1'b0, 8'h00, 16'd400);
    send(1'b0, 8'hFF, 16'd1);
    expect_out("R2", 1'b0, 16'd400);
    send(1'b0, 8'h02, 16'd2);
    expect_out("R4 hold", 1'b0, 16'd400);
    send(1'b0, 8'h04, 16'd3);
    expect_out("R4 hold", 1'b0, 16'd400);
    send(1'b0, 8'h00, 16'd800);
    expect_out("R4 run end average", 1'b0, 16'd600);
  endtask

  task automatic t_channels();
    do_reset();
    send(1'b1, 8'h00, 16'd10);
    send(1'b0, 8'h00, 16'd5000);
    expect_none("R5 right empty");
    send(1'b1, 8'h80, 16'd9999);
    expect_out("R5 left", 1'b1, 16'd10);
    send(1'b0, 8'h00, 16'd6000);
    expect_out("R5 right", 1'b0, 16'd5000);
    send(1'b1, 8'h00, 16'd30);
    expect_out("R5 R3 left average", 1'b1, 16'd20);
    send(1'b0, 8'h00, 16'd7000);
    expect_out("R5 right", 1'b0, 16'd6000);
  endtask

  task automatic t_mute();
    do_reset();
    send(1'b1, 8'h00, 16'd777);
    mute_pin = 1'b1;
    send(1'b0, 8'h00, 16'd55);
    expect_none("R5 R6 right empty");
    send(1'b1, 8'h00, 16'd888);
    expect_out("R6 full mute", 1'b1, 16'd0);
  endtask

  task automatic t_atten();
    do_reset();
    send(1'b1, 8'h00, 16'd4000);
    attm_en = 1'b1;
    send(1'b1, 8'h00, 16'hF060);
    expect_out("R7 positive", 1'b1, 16'd1000);
    send(1'b1, 8'h00, 16'hFFFB);
    expect_out("R7 negative", 1'b1, 16'hFC18);
    mute_pin = 1'b1;
    send(1'b1, 8'h00, 16'd0);
    expect_out("R7 with mute floor", 1'b1, 16'hFFFE);
  endtask

  task automatic t_zero_cross();
    do_reset();
    send(1'b1, 8'h00, 16'h1234);
    zc_en = 1'b1; mute_pin = 1'b1;
    send(1'b1, 8'h00, 16'hFC10);
    expect_out("R8 wait", 1'b1, 16'h1234);
    send(1'b1, 8'h00, 16'h0100);
    expect_out("R8 crossing muted", 1'b1, 16'h0000);
    send(1'b1, 8'h00, 16'h1234);
    expect_out("R8 stays muted", 1'b1, 16'h0000);
    mute_pin = 1'b0;
    send(1'b1, 8'h00, 16'h0042);
    expect_out("R8 released", 1'b1, 16'h1234);
  endtask

  bit finished = 1'b0;

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = '0; in_left = 1'b0;
    mute_pin = 1'b0; zc_en = 1'b0; attm_en = 1'b0;
    t_reset();
    t_isolated();
    t_run();
    t_channels();
    t_mute();
    t_atten();
    t_zero_cross();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule